// File: doc/BRIEF.md
# Wavetable Synth Voice with Frequency Modulation

A single audio voice that steps through a 64-entry, 6-bit waveform held in local RAM. The position in that waveform comes from a 25-bit phase accumulator whose increment is the carrier pitch. A second, slower accumulator walks a 32-entry table of 3-bit modulation codes. The selected code, scaled by a modulation gain, sets how many of the carrier's eight bit-serial partial sums land in the phase in each 8-step cycle. This bends the pitch up or down.

Two envelope generators own the volume gain and the modulation gain. Each can be loaded directly or left to ramp up or down at a programmed rate, and one control bit freezes both. The output sample is the waveform value times the volume gain, capped at 32, then scaled by a selectable master divider. It is registered and refreshed once per voice clock. The voice clock is an internal enable that fires on every second cycle of the host clock. The host writes eleven control registers and the wave RAM through one write port. It reads either gain back with the two top bits supplied from outside.

Address map: `addr_i[6]=1` selects wave RAM entry `addr_i[5:0]`. `addr_i[6]=0` selects control register `addr_i[3:0]`.

Top module: `wt_voice`

## Requirements
- R1: A write to wave RAM (addr bit 6 set) stores `wdata_i[5:0]` only while register 9 bit 7 is 1; otherwise it is dropped. While register 9 bit 7 is 1, `sample_o` is 0.
- R2: `sample_o` = wave[index] × min(volume gain, 32) × 4 / (M + 2), truncated, where M is register 9 bits 1:0. It is 0 after reset and refreshes once per voice clock (every second host clock).
- R3: The volume gain used in the product saturates at 32, so the output never exceeds 4032.
- R4: With `rd_sel_i`=0 `rd_data_o` = {`open_bus_i`, volume gain}; with `rd_sel_i`=1 it carries the modulation gain in bits 5:0 instead.
- R5: Writing register 0 (volume) or register 4 (modulation) with bit 7 set loads bits 5:0 into that gain on the next cycle.
- R6: With bit 7 clear, the envelope counts the gain up (bit 6 = 1) saturating at 63, or down (bit 6 = 0) saturating at 0, one step at a time.
- R7: An envelope tick occurs every (register 10 × 3) voice clocks (every voice clock if that is 0). A running envelope steps on every (bits 5:0 + 1)-th tick.
- R8: Register 3 bit 6 set freezes both gains against envelope steps; direct loads still apply.
- R9: The carrier frequency is {reg3[3:0], reg2}. In step k (0..7) of each 8-voice-clock cycle, frequency << k is added to the 25-bit phase when bit k of the modulation byte is 1. The wave index is phase bits 24:19.
- R10: A register 8 write stores bits 2:0 at a 5-bit table pointer that then increments and wraps from 31 to 0. A register 7 write clears the pointer and the 18-bit modulation accumulator.
- R11: At step 0 the modulation accumulator adds {reg7[3:0], reg6}, and the code at accumulator bits 17:13 is read. With m = code[1:0] and g = modulation gain, the adjustment is 0 if m = 0, +2·g·m if code[2] = 0, and −2·g·(4−m) otherwise. It is clamped to −128..127, and the modulation byte is 128 plus the adjustment.
- R12: Register 7 bit 7 set forces the modulation byte to 128, giving one full-weight add per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 7 | Bit 6 selects wave RAM; bits 5:0 entry or bits 3:0 register |
| wdata_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Readback select: 0 volume gain, 1 modulation gain |
| open_bus_i | input | 2 | Value placed in readback bits 7:6 |
| rd_data_o | output | 8 | Gain readback |
| sample_o | output | 12 | Unsigned output sample |

## Verification
Assertions check every cycle that an unloaded gain moves by at most one, and that a frozen gain holds. They also check that a direct load lands, that the phase is untouched when no add is selected, that the forced modulation byte is 128, that the table pointer steps by one, that a muted voice outputs zero and that the sample stays within its bound. Only the bench scenarios can show the arithmetic end to end. They check the output value under each master divider and the volume cap, the envelope ramp rates and saturation, and the pitch rate for each kind of modulation code, clamp and table wrap. The pitch rate is measured as the number of sample changes in a fixed window over a ramp waveform.

// File: rtl/wt_voice_pkg.sv
package wt_voice_pkg;
  localparam int WAVE_AW  = 6;
  localparam int WAVE_DW  = 6;
  localparam int GAIN_W   = 6;
  localparam int MTAB_AW  = 5;
  localparam int MTAB_DW  = 3;
  localparam int FREQ_W   = 12;
  localparam int PHASE_W  = 25;
  localparam int MACC_W   = 18;
  localparam int STEPS    = 8;
  localparam int STEP_W   = $clog2(STEPS);
  localparam int VOL_CAP  = 32;
  localparam int SAMPLE_W = 12;
  localparam int ESPD_W   = 8;
  localparam int ECNT_W   = ESPD_W + 2;

  localparam logic [3:0] A_VOL    = 4'd0;
  localparam logic [3:0] A_CF_LO  = 4'd2;
  localparam logic [3:0] A_CF_HI  = 4'd3;
  localparam logic [3:0] A_MOD    = 4'd4;
  localparam logic [3:0] A_MF_LO  = 4'd6;
  localparam logic [3:0] A_MF_HI  = 4'd7;
  localparam logic [3:0] A_MTAB   = 4'd8;
  localparam logic [3:0] A_MASTER = 4'd9;
  localparam logic [3:0] A_ESPD   = 4'd10;

  // signed code x gain, doubled, clamped, offset to unsigned byte
  function automatic logic [7:0] mod_byte(logic [MTAB_DW-1:0] code, logic [GAIN_W-1:0] gain);
    int g, m, adj;
    g = int'(gain);
    m = int'(code[1:0]);
    if (m == 0)        adj = 0;
    else if (code[2])  adj = -2 * g * (4 - m);
    else               adj = 2 * g * m;
    if (adj > 127)  adj = 127;
    if (adj < -128) adj = -128;
    return 8'(adj + 128);
  endfunction
endpackage

// File: rtl/wt_envelope.sv
module wt_envelope
  import wt_voice_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              env_tick_i,
  input  logic              halt_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = GAIN_W'((1 << GAIN_W) - 1);

  logic [7:0]        ctrl_q;
  logic [GAIN_W-1:0] gain_q, div_q, gain_step;

  always_comb begin
    gain_step = gain_q;
    if (ctrl_q[6]) begin
      if (gain_q != GAIN_MAX) gain_step = gain_q + GAIN_W'(1);
    end else begin
      if (gain_q != '0) gain_step = gain_q - GAIN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      gain_q <= '0;
      div_q  <= '0;
    end else if (wr_i) begin
      ctrl_q <= wdata_i;
      if (wdata_i[7]) gain_q <= wdata_i[GAIN_W-1:0];
    end else if (env_tick_i && !ctrl_q[7] && !halt_i) begin
      if (div_q == '0) begin
        gain_q <= gain_step;
        div_q  <= ctrl_q[GAIN_W-1:0];
      end else begin
        div_q <= div_q - GAIN_W'(1);
      end
    end
  end

  assign gain_o = gain_q;

  p_gain_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + GAIN_W'(1))
              || (gain_q == $past(gain_q) - GAIN_W'(1)));
  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !wr_i |=> $stable(gain_q));
  p_direct_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[7] |=> gain_q == $past(wdata_i[GAIN_W-1:0]));
endmodule

// File: rtl/wt_mod_unit.sv
module wt_mod_unit
  import wt_voice_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               step0_i,
  input  logic               tab_wr_i,
  input  logic [MTAB_DW-1:0] tab_data_i,
  input  logic               clr_i,
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic               force_mid_i,
  input  logic [GAIN_W-1:0]  gain_i,
  output logic               add_en_o
);
  localparam int TAB_N = 1 << MTAB_AW;

  logic [MTAB_DW-1:0] tab_q [TAB_N];
  logic [MTAB_AW-1:0] ptr_q;
  logic [MACC_W-1:0]  acc_q, acc_next;
  logic [7:0]         sh_q, sh_next;
  logic [MTAB_DW-1:0] code;

  assign acc_next = acc_q + MACC_W'(freq_i);
  assign code     = tab_q[acc_next[MACC_W-1 -: MTAB_AW]];

  always_comb begin
    if (!step0_i)         sh_next = sh_q >> 1;
    else if (force_mid_i) sh_next = 8'h80;
    else                  sh_next = mod_byte(code, gain_i);
  end

  assign add_en_o = sh_next[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAB_N; i++) tab_q[i] <= '0;
      ptr_q <= '0;
      acc_q <= '0;
      sh_q  <= 8'h80;
    end else begin
      if (tab_wr_i) begin
        tab_q[ptr_q] <= tab_data_i;
        ptr_q        <= ptr_q + MTAB_AW'(1);
      end
      if (clr_i) begin
        ptr_q <= '0;
        acc_q <= '0;
      end else if (tick_i && step0_i) begin
        acc_q <= acc_next;
      end
      if (tick_i) sh_q <= sh_next;
    end
  end

  p_force_mid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && step0_i && force_mid_i |=> sh_q == 8'h80);
  p_ptr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tab_wr_i && !clr_i |=> ptr_q == $past(ptr_q) + MTAB_AW'(1));
  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == '0 && acc_q == '0);
endmodule

// File: rtl/wt_phase.sv
module wt_phase
  import wt_voice_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               step0_i,
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic               add_en_i,
  output logic [WAVE_AW-1:0] index_o
);
  localparam int SH_W = FREQ_W + STEPS - 1;

  logic [SH_W-1:0]    fsh_q, fsh_next;
  logic [PHASE_W-1:0] phase_q;

  assign fsh_next = step0_i ? SH_W'(freq_i) : (fsh_q << 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsh_q   <= '0;
      phase_q <= '0;
    end else if (tick_i) begin
      fsh_q <= fsh_next;
      if (add_en_i) phase_q <= phase_q + PHASE_W'(fsh_next);
    end
  end

  assign index_o = phase_q[PHASE_W-1 -: WAVE_AW];

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));
  p_no_add_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !add_en_i |=> $stable(phase_q));
endmodule

// File: rtl/wt_voice.sv
module wt_voice
  import wt_voice_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [6:0]          addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                rd_sel_i,
  input  logic [1:0]          open_bus_i,
  output logic [7:0]          rd_data_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int WAVE_N     = 1 << WAVE_AW;
  localparam int PROD_W     = WAVE_DW + GAIN_W;
  localparam int SAMPLE_MAX = ((1 << WAVE_DW) - 1) * VOL_CAP * 2;

  logic              tick_q;
  logic [STEP_W-1:0] step_q;
  logic              step0;

  logic [7:0]  cf_lo_q, mf_lo_q;
  logic [3:0]  cf_hi_q, mf_hi_q;
  logic        halt_q, force_mid_q, mute_q;
  logic [1:0]  master_q;
  logic [ESPD_W-1:0] espd_q;
  logic [ECNT_W-1:0] ecnt_q, eperiod;
  logic        env_tick;

  logic [WAVE_DW-1:0] wave_q [WAVE_N];
  logic [WAVE_AW-1:0] index;
  logic               add_en;
  logic [GAIN_W-1:0]  gain_w [2];

  logic               reg_wr;
  logic [3:0]         reg_a;
  logic [GAIN_W-1:0]  vol_eff;
  logic [PROD_W-1:0]  prod;
  logic [SAMPLE_W-1:0] scaled;
  logic [SAMPLE_W-1:0] sample_q;

  assign reg_wr = wr_i && !addr_i[6];
  assign reg_a  = addr_i[3:0];
  assign step0  = (step_q == '0);

  // voice clock enable: every second host cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      step_q <= '0;
    end else begin
      tick_q <= ~tick_q;
      if (tick_q) step_q <= step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_lo_q <= '0; cf_hi_q <= '0; halt_q <= 1'b0;
      mf_lo_q <= '0; mf_hi_q <= '0; force_mid_q <= 1'b0;
      mute_q <= 1'b0; master_q <= '0; espd_q <= '0;
    end else if (reg_wr) begin
      unique case (reg_a)
        A_CF_LO:  cf_lo_q <= wdata_i;
        A_CF_HI:  begin cf_hi_q <= wdata_i[3:0]; halt_q <= wdata_i[6]; end
        A_MF_LO:  mf_lo_q <= wdata_i;
        A_MF_HI:  begin mf_hi_q <= wdata_i[3:0]; force_mid_q <= wdata_i[7]; end
        A_MASTER: begin mute_q <= wdata_i[7]; master_q <= wdata_i[1:0]; end
        A_ESPD:   espd_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAVE_N; i++) wave_q[i] <= '0;
    end else if (wr_i && addr_i[6] && mute_q) begin
      wave_q[addr_i[WAVE_AW-1:0]] <= wdata_i[WAVE_DW-1:0];
    end
  end

  // envelope tick divider
  assign eperiod  = ECNT_W'(espd_q) * ECNT_W'(3);
  assign env_tick = tick_q && (ecnt_q + ECNT_W'(1) >= eperiod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ecnt_q <= '0;
    else if (env_tick) ecnt_q <= '0;
    else if (tick_q)   ecnt_q <= ecnt_q + ECNT_W'(1);
  end

  for (genvar g = 0; g < 2; g++) begin : g_env
    localparam logic [3:0] ADDR = (g == 0) ? A_VOL : A_MOD;
    wt_envelope u_env (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_wr && reg_a == ADDR),
      .wdata_i    (wdata_i),
      .env_tick_i (env_tick),
      .halt_i     (halt_q),
      .gain_o     (gain_w[g])
    );
  end

  wt_mod_unit u_mod (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_q),
    .step0_i     (step0),
    .tab_wr_i    (reg_wr && reg_a == A_MTAB),
    .tab_data_i  (wdata_i[MTAB_DW-1:0]),
    .clr_i       (reg_wr && reg_a == A_MF_HI),
    .freq_i      ({mf_hi_q, mf_lo_q}),
    .force_mid_i (force_mid_q),
    .gain_i      (gain_w[1]),
    .add_en_o    (add_en)
  );

  wt_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_q),
    .step0_i  (step0),
    .freq_i   ({cf_hi_q, cf_lo_q}),
    .add_en_i (add_en),
    .index_o  (index)
  );

  // output scaling
  assign vol_eff = (gain_w[0] > GAIN_W'(VOL_CAP)) ? GAIN_W'(VOL_CAP) : gain_w[0];
  assign prod    = PROD_W'(wave_q[index]) * PROD_W'(vol_eff);

  always_comb begin
    unique case (master_q)
      2'd0:    scaled = SAMPLE_W'({prod, 1'b0});
      2'd1:    scaled = SAMPLE_W'({prod, 2'b00} / (PROD_W + 2)'(3));
      2'd2:    scaled = SAMPLE_W'(prod);
      default: scaled = SAMPLE_W'({prod, 2'b00} / (PROD_W + 2)'(5));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_q <= '0;
    else if (tick_q) sample_q <= mute_q ? '0 : scaled;
  end

  assign sample_o  = sample_q;
  assign rd_data_o = {open_bus_i, rd_sel_i ? gain_w[1] : gain_w[0]};

  p_mute_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q && mute_q |=> sample_o == '0);
  p_sample_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o <= SAMPLE_W'(SAMPLE_MAX));
  p_step_adv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> step_q == $past(step_q) + STEP_W'(1));
endmodule

// File: tb/wt_voice_bench.sv
`timescale 1ns/1ps
module wt_voice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_sel = 1'b0;
  logic [1:0]  open_bus = '0;
  logic [7:0]  rd_data;
  logic [11:0] sample;

  always #4 clk = ~clk;

  wt_voice u_wt_voice (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rd_sel_i(rd_sel), .open_bus_i(open_bus), .rd_data_o(rd_data), .sample_o(sample)
  );

  typedef struct { string tag; int src; int lo; int hi; } exp_t;
  exp_t sb_q[$];
  event chk_ev;
  int n_chk = 0, n_err = 0, meas = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares against the observed value
  initial forever begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      exp_t it;
      int act;
      it  = sb_q.pop_front();
      act = (it.src == 0) ? int'(sample) : (it.src == 1) ? int'(rd_data) : meas;
      n_chk++;
      if (act < it.lo || act > it.hi) begin
        n_err++;
        $display("FAIL %s actual=%0d expected=%0d..%0d", it.tag, act, it.lo, it.hi);
      end
    end
  end

  task automatic expect_v(string tag, int src, int lo, int hi);
    exp_t it;
    it.tag = tag; it.src = src; it.lo = lo; it.hi = hi;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    wr = 1'b1; addr = 7'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_wave(int a, int d);
    wr_reg(64 + a, d);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_changes(int n);
    logic [11:0] prev;
    idle(32);
    prev = sample;
    meas = 0;
    repeat (n) begin
      @(negedge clk);
      if (sample != prev) meas++;
      prev = sample;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(4);
    expect_v("R2 reset sample", 0, 0, 0);
    rd_sel = 1'b0; open_bus = 2'b00;
    expect_v("R4 reset volume gain", 1, 0, 0);

    wr_reg(0, 8'h80 | 20);
    open_bus = 2'b11;
    expect_v("R4 R5 volume readback with bus bits", 1, 8'hD4, 8'hD4);
    open_bus = 2'b00;

    wr_wave(0, 40);
    idle(4);
    expect_v("R1 wave write while unlocked is dropped", 0, 0, 0);

    wr_reg(9, 8'h80);
    wr_wave(0, 40);
    for (int i = 1; i < 64; i++) wr_wave(i, i);
    idle(4);
    expect_v("R1 muted output", 0, 0, 0);

    wr_reg(9, 0); idle(4);
    expect_v("R2 master 0", 0, 1600, 1600);
    wr_reg(9, 1); idle(4);
    expect_v("R2 master 1", 0, 1066, 1066);
    wr_reg(9, 2); idle(4);
    expect_v("R2 master 2", 0, 800, 800);
    wr_reg(9, 3); idle(4);
    expect_v("R2 master 3", 0, 640, 640);

    wr_reg(9, 0);
    wr_reg(0, 8'h80 | 50); idle(4);
    expect_v("R3 volume capped at 32", 0, 2560, 2560);
    expect_v("R4 R5 volume gain 50", 1, 50, 50);

    wr_reg(4, 8'h89);
    rd_sel = 1'b1; open_bus = 2'b11;
    expect_v("R4 R5 modulation readback", 1, 8'hC9, 8'hC9);
    rd_sel = 1'b0; open_bus = 2'b00;

    // envelopes: tick every 3 voice clocks = 6 host cycles
    wr_reg(10, 1);
    wr_reg(3, 8'h40);
    wr_reg(0, 8'h80 | 10);
    wr_reg(0, 8'h40);
    idle(200);
    expect_v("R8 halt freezes volume", 1, 10, 10);
    wr_reg(3, 8'h00);
    idle(60);
    expect_v("R7 rate 0 ramp up", 1, 19, 21);
    idle(2000);
    expect_v("R6 saturate at 63", 1, 63, 63);
    wr_reg(0, 8'h00);
    idle(1000);
    expect_v("R6 ramp down to 0", 1, 0, 0);
    wr_reg(0, 8'h80);
    wr_reg(0, 8'h43);
    idle(240);
    expect_v("R7 rate 3 ramp up", 1, 9, 11);

    // pitch tests: carrier 0x800, ramp waveform, volume 32
    wr_reg(3, 8'h48);
    wr_reg(2, 0);
    wr_reg(0, 8'h80 | 32);
    wr_reg(4, 8'h80 | 10);
    wr_reg(6, 0);
    wr_reg(7, 8'h80);
    count_changes(1024);
    expect_v("R12 R9 forced mid rate", 2, 31, 33);

    wr_reg(7, 0);
    for (int i = 0; i < 32; i++) wr_reg(8, 1);
    count_changes(1024);
    expect_v("R11 positive code rate", 2, 36, 38);

    wr_reg(8, 5);
    count_changes(1024);
    expect_v("R10 pointer wraps to entry 0", 2, 16, 18);

    wr_reg(7, 0);
    wr_reg(8, 1);
    count_changes(1024);
    expect_v("R10 register 7 clears pointer", 2, 36, 38);

    wr_reg(4, 8'h80 | 63);
    wr_reg(7, 0); wr_reg(8, 3);
    count_changes(1024);
    expect_v("R11 positive clamp", 2, 62, 65);

    wr_reg(7, 0); wr_reg(8, 5);
    count_changes(1024);
    expect_v("R11 negative clamp", 2, 0, 0);

    wr_reg(7, 8'h80);
    count_changes(1024);
    expect_v("R12 force overrides negative code", 2, 31, 33);

    wr_reg(7, 0); wr_reg(8, 4);
    count_changes(1024);
    expect_v("R11 zero magnitude", 2, 31, 33);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule